// File: doc/BRIEF.md
# GPIO Port with Change-Detect Interrupt

This block is an eight-pin general-purpose I/O port controller that sits behind a simple single-cycle register bus. Software sets each pin's direction, writes output data into a latch, and reads the pin levels back. The block drives per-pin output-enable, output-data and weak pull-up enables to the pads, plus an analog-select signal for the low five pins.

The upper four pins can raise a change interrupt. Each of those pins that is an input is compared against a snapshot taken the last time software accessed the port register. Any difference sets a sticky flag. Because the comparison is against that snapshot and not against the previous clock sample, the flag cannot be cleared until software has read or written the port register. Pin inputs pass through a two-flop synchroniser before both the read path and the comparison.

The bus has no back-pressure. A transfer is one cycle with `bus_sel` high: a write when `bus_wr` is high, a read otherwise. Read data comes back with `bus_rvalid` on the following cycle, and a new access may be issued every cycle.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction register reads 0xFF (all inputs), the latch reads 0x00, the analog-select register reads 0x1F, and the control register reads 0x80. At the pads, `pad_oe`, `pad_pu` and `irq` are 0 and `pad_ana` is 0x1F.
- R2: Direction register (address 2) bit value 1 means input and 0 means output. `pad_oe[i]` is the inverse of that bit, and `pad_out` always carries the output latch.
- R3: The latch register (address 1) reads back the latched value whatever the pin levels are. A write to the port register (address 0) also loads the latch.
- R4: A read of the port register returns the synchronised pin levels. Any of bits 4:0 whose analog-select bit (address 3) is 1 reads as 0.
- R5: A pin in bits 7:4 that is an input and differs from the snapshot sets the change flag (control bit 0, address 4). Bits 3:0, and upper pins set as outputs, never set it.
- R6: While a mismatch persists, writing 0 to the flag bit does not clear it. After any read or write of the port register refreshes the snapshot, a write of 0 clears it.
- R7: Writing 1 to the flag bit never sets it.
- R8: `irq` equals the flag ANDed with the interrupt-enable bit (control bit 1).
- R9: Control bit 7 is an active-low global pull-up enable. `pad_pu[i]` is 1 only when that bit is 0 and pin i is an input.
- R10: `pad_ana` mirrors the analog-select register bits 4:0. Upper bits of that register read 0.
- R11: Every read returns its data with `bus_rvalid` high exactly one cycle after the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per transfer |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pin_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Output-driver enable per pin |
| pad_out | output | 8 | Output data per pin |
| pad_pu | output | 8 | Weak pull-up enable per pin |
| pad_ana | output | 5 | Analog mode select for pins 4:0 |
| irq | output | 1 | Change interrupt request |

## Verification
The hardest state to reach from the ports is a change mismatch that is still present while software tries to clear the flag. In that state the clear write has to be seen to fail, and the same write has to succeed once a port access has refreshed the snapshot. The stimulus gets there by moving the upper pins, waiting out the synchroniser, and issuing the clear write before any port access. It then repeats the clear after a port read in one case and after a port write in another. Exclusion is shown by moving the low pins, and by moving upper pins that have been set as outputs, and confirming that the flag stays clear.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PORT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LATCH = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_ANSEL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
  localparam int C_FLAG = 0;
  localparam int C_IEN  = 1;
  localparam int C_PUN  = 7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] is_in,
  input  logic         snap_ld,
  input  logic         clr_req,
  output logic         mism,
  output logic         flag
);
  logic [N-1:0] snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap <= '0;
    else if (snap_ld) snap <= pin_s;
  end

  assign mism = |((pin_s ^ snap) & is_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (mism) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  // R6
  mism_holds_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mism |=> flag);
  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !mism) |=> !flag);
  // R7
  set_needs_mism_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(mism));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int W   = 8,
  parameter int ANA = 5
) (
  input  logic           dir_in,
  input  logic [W-1:0]   dir,
  input  logic [W-1:0]   latch,
  input  logic           pu_n,
  input  logic [ANA-1:0] ansel,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_out,
  output logic [W-1:0]   pad_pu,
  output logic [ANA-1:0] pad_ana
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign pad_oe[i]  = ~dir[i] & dir_in;
      assign pad_out[i] = latch[i];
      assign pad_pu[i]  = ~pu_n & dir[i];
    end
  endgenerate
  assign pad_ana = ansel;
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int W       = 8,
  parameter int CHG_LO  = 4,
  parameter int ANA     = 5,
  parameter int SYNC_ST = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [2:0]     bus_addr,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  output logic           bus_rvalid,
  input  logic [W-1:0]   pin_in,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_out,
  output logic [W-1:0]   pad_pu,
  output logic [ANA-1:0] pad_ana,
  output logic           irq
);
  localparam int CHG_N = W - CHG_LO;

  logic [W-1:0]   dir_q, latch_q, pin_s, ana_mask, rd_mux;
  logic [ANA-1:0] ansel_q;
  logic           ien_q, pun_q, flag, mism;
  logic           wr_en, rd_en, port_acc, clr_req;
  logic           unused_wbits;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign port_acc = bus_sel & (bus_addr == A_PORT);
  assign clr_req  = wr_en & (bus_addr == A_CTRL) & ~bus_wdata[C_FLAG];
  assign unused_wbits = ^bus_wdata[C_PUN-1:C_IEN+1];

  gpio_sync #(.W(W), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  gpio_chg_detect #(.N(CHG_N)) u_chg (
    .clk(clk), .rst_n(rst_n),
    .pin_s(pin_s[W-1:CHG_LO]), .is_in(dir_q[W-1:CHG_LO]),
    .snap_ld(port_acc), .clr_req(clr_req),
    .mism(mism), .flag(flag)
  );

  gpio_pad_ctrl #(.W(W), .ANA(ANA)) u_pad (
    .dir_in(1'b1), .dir(dir_q), .latch(latch_q), .pu_n(pun_q), .ansel(ansel_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_ana(pad_ana)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      latch_q <= '0;
      ansel_q <= '1;
      ien_q   <= 1'b0;
      pun_q   <= 1'b1;
    end else if (wr_en) begin
      case (bus_addr)
        A_PORT, A_LATCH: latch_q <= bus_wdata;
        A_DIR:   dir_q   <= bus_wdata;
        A_ANSEL: ansel_q <= bus_wdata[ANA-1:0];
        A_CTRL: begin
          ien_q <= bus_wdata[C_IEN];
          pun_q <= bus_wdata[C_PUN];
        end
        default: ;
      endcase
    end
  end

  assign ana_mask = {{(W-ANA){1'b0}}, ansel_q};

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_PORT:  rd_mux = pin_s & ~ana_mask;
      A_LATCH: rd_mux = latch_q;
      A_DIR:   rd_mux = dir_q;
      A_ANSEL: rd_mux = ana_mask;
      A_CTRL: begin
        rd_mux[C_FLAG] = flag;
        rd_mux[C_IEN]  = ien_q;
        rd_mux[C_PUN]  = pun_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end

  assign irq = flag & ien_q;

  // R11
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> bus_rvalid);
  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (bus_addr == A_LATCH || bus_addr == A_PORT)) |=> pad_out == $past(bus_wdata));
  // R9
  pu_off_for_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);
endmodule

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, pin_in = 0;
  logic [7:0] bus_rdata, pad_oe, pad_out, pad_pu;
  logic [4:0] pad_ana;
  logic       bus_rvalid, irq;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  gpio_chg_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu), .pad_ana(pad_ana), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as rvalid appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R11 unexpected rvalid", 8'h1, 8'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
    @(negedge clk);
  endtask

  task automatic pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      check("watchdog", 8'h1, 8'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 R10 pad_ana", {3'd0, pad_ana}, 8'h1F);
    rd(3'd2, 8'hFF, "R1 dir");
    rd(3'd1, 8'h00, "R1 latch");
    rd(3'd3, 8'h1F, "R1 R10 ansel");
    rd(3'd4, 8'h80, "R1 ctrl");
    // R5 upper-pin change against reset snapshot
    pins(8'hA5);
    check("R8 irq off while disabled", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h80);                          // clear attempt during mismatch
    rd(3'd4, 8'h81, "R5 R6 flag held");
    wr(3'd4, 8'h83);                          // enable, flag bit written 1
    @(negedge clk);
    check("R8 irq enabled", {7'd0, irq}, 8'h01);
    rd(3'd0, 8'hA0, "R4 analog bits read 0");
    wr(3'd4, 8'h82);
    @(negedge clk);
    check("R6 cleared after port read", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h83);
    rd(3'd4, 8'h82, "R7 write 1 no set");
    // R5 low pins excluded
    pins(8'hAA);
    rd(3'd4, 8'h82, "R5 low pins excluded");
    wr(3'd3, 8'h00);
    check("R10 pad_ana cleared", {3'd0, pad_ana}, 8'h00);
    rd(3'd3, 8'h00, "R10 ansel readback");
    rd(3'd0, 8'hAA, "R4 digital read");
    // R5 outputs excluded, R2 direction
    wr(3'd2, 8'h0F);
    wr(3'd1, 8'h3C);
    @(negedge clk);
    check("R2 pad_oe", pad_oe, 8'hF0);
    check("R2 pad_out", pad_out, 8'h3C);
    pins(8'h5A);
    rd(3'd4, 8'h82, "R5 outputs excluded");
    check("R5 irq low", {7'd0, irq}, 8'h00);
    rd(3'd1, 8'h3C, "R3 latch vs pins");
    rd(3'd0, 8'h5A, "R4 pin level");
    wr(3'd0, 8'h99);
    rd(3'd1, 8'h99, "R3 port write loads latch");
    check("R3 pad_out", pad_out, 8'h99);
    // R9 pull-ups
    wr(3'd4, 8'h02);
    @(negedge clk);
    check("R9 pu inputs only", pad_pu, 8'h0F);
    wr(3'd2, 8'hFF);
    @(negedge clk);
    check("R9 pu all", pad_pu, 8'hFF);
    check("R2 all inputs", pad_oe, 8'h00);
    // R6 via port write
    pins(8'h6A);
    check("R5 flag from bit4", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h02);
    @(negedge clk);
    check("R6 clear blocked", {7'd0, irq}, 8'h01);
    wr(3'd0, 8'h11);
    wr(3'd4, 8'h02);
    @(negedge clk);
    check("R6 clear after port write", {7'd0, irq}, 8'h00);
    repeat (3) @(negedge clk);
    check("R11 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule